// File: doc/BRIEF.md
# Frame-Synchronous Descrambler with BIP-8 Monitor

This block sits on one received byte-wide stream once framing has been found. A frame-start pulse marks the first framing byte, and from it the block tracks the position of every byte in the frame. Bytes that follow the first-row overhead are descrambled with a 127-bit frame-synchronous keystream. The framing bytes, the trace byte and the growth bytes pass through unchanged.

While the stream runs, the block folds every received byte, still scrambled, into an 8-bit even bit-interleaved parity for the frame. At the first byte of row 2 of the next frame, after that byte is descrambled, the block compares it with this parity. Each differing bit adds one to a wrapping error counter.

The output stage can overwrite the data with all ones as an alarm indication. This happens either on a configuration bit, or on an out-of-frame input when a second bit allows it. Each output byte carries an even parity bit, and the frame-start pulse is delayed so that it stays aligned with the data.

Top module: `bip8dsc_top`

## Requirements
- R1: `in_fsync` high marks the current input byte as frame position 0. Without it, the position advances by one per byte and wraps from FRAME_BYTES-1 (ROW_BYTES*ROWS) to 0. After reset, the first byte counts as position 0.
- R2: Positions 0 to OH_LEN-1 (OH_LEN = A1_CNT+A2_CNT+1+Z0_CNT) leave the block unchanged when no alarm is forced.
- R3: From position OH_LEN to the end of the frame, each byte is XORed with a keystream from a 7-bit register. The register is all ones for the byte at OH_LEN. Each keystream bit is the register MSB, after which the register shifts left and the XOR of its two top bits enters at bit 0. The first bit of each byte's key applies to data bit 7.
- R4: With `cfg_descr_off` high, every byte passes through unchanged.
- R5: The parity is the XOR of all raw input bytes at positions 0 to FRAME_BYTES-1 of a frame. At position ROW_BYTES of the following frame, the descrambled byte is compared with it. `b1_err_cnt` increases by the number of differing bits, modulo 2^CNT_W.
- R6: No comparison is made if the frame whose parity would be used was not a complete FRAME_BYTES run that started after an observed `in_fsync`. This covers the first frame after the first sync and any frame cut short by a sync.
- R7: With `cfg_ais_force` high, the output byte is 0xFF. The parity comparison still uses the descrambled data.
- R8: With `cfg_ais_on_oof` and `in_oof` both high, the output byte is 0xFF. Either one alone has no effect.
- R9: `out_par` is the XOR of the 8 bits of `out_data`, so the 9 bits have even weight.
- R10: `out_data`, `out_par` and `out_fsync` appear one clock after the input byte. `b1_err_cnt` updates on the clock that registers the compared byte.
- R11: During reset, `out_data`, `out_par`, `out_fsync` and `b1_err_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Received scrambled byte |
| in_fsync | input | 1 | Marks the first framing byte of a frame |
| in_oof | input | 1 | Out-of-frame indication from the framer |
| cfg_descr_off | input | 1 | Bypass the descrambler |
| cfg_ais_force | input | 1 | Force all-ones output |
| cfg_ais_on_oof | input | 1 | Allow all-ones output while out of frame |
| out_data | output | 8 | Descrambled byte or alarm pattern |
| out_par | output | 1 | Even parity of out_data |
| out_fsync | output | 1 | Frame-start pulse aligned with out_data |
| b1_err_cnt | output | CNT_W | Wrapping count of parity bit errors |

## Verification
A wrong position count or keystream state is visible on the next output byte. Every byte after the overhead comes out as a different value than the keystream model predicts, and a misplaced overhead window shows up on the first or last growth byte. A wrong parity accumulator or an invalid-frame flag has no effect on the data and appears only in `b1_err_cnt`. It is seen one clock after the row-2 byte of the next frame, so the bench injects known bit-error patterns there on many frames.

// File: rtl/bip8dsc_pkg.sv
package bip8dsc_pkg;

    typedef struct packed {
        logic [7:0] key;
        logic [6:0] nxt;
    } ks_step_t;

    // Advance the 1 + x^6 + x^7 generator by eight bits, MSB-first key.
    function automatic ks_step_t ks_step8(input logic [6:0] st);
        ks_step_t r;
        logic [6:0] s;
        s = st;
        r.key = '0;
        for (int i = 7; i >= 0; i--) begin
            r.key[i] = s[6];
            s = {s[5:0], s[6] ^ s[5]};
        end
        r.nxt = s;
        return r;
    endfunction

    function automatic logic [3:0] pop8(input logic [7:0] v);
        logic [3:0] c;
        c = '0;
        for (int i = 0; i < 8; i++) c = c + {3'b000, v[i]};
        return c;
    endfunction

endpackage

// File: rtl/bip8dsc_timing.sv
module bip8dsc_timing #(
    parameter int ROW_BYTES = 1080,
    parameter int ROWS      = 9,
    parameter int A1_CNT    = 12,
    parameter int A2_CNT    = 12,
    parameter int Z0_CNT    = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic is_start,
    output logic is_oh,
    output logic is_seed,
    output logic is_b1,
    output logic frame_ok
);
    localparam int FRAME_BYTES = ROW_BYTES * ROWS;
    localparam int OH_LEN      = A1_CNT + A2_CNT + 1 + Z0_CNT;
    localparam int POS_W       = $clog2(FRAME_BYTES);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BYTES - 1);
    localparam logic [POS_W-1:0] OH_POS   = POS_W'(OH_LEN);
    localparam logic [POS_W-1:0] B1_POS   = POS_W'(ROW_BYTES);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             seen;
        logic             ok;
    } tm_t;

    tm_t tm_d, tm_q;
    logic [POS_W-1:0] cur_pos;

    always_comb begin
        tm_d = tm_q;
        if (fsync || tm_q.pos == LAST_POS) cur_pos = '0;
        else                               cur_pos = tm_q.pos + 1'b1;
        tm_d.pos  = cur_pos;
        tm_d.seen = tm_q.seen | fsync;
        if (cur_pos == '0)
            tm_d.ok = tm_q.seen && (tm_q.pos == LAST_POS);
        is_start = (cur_pos == '0);
        is_oh    = (cur_pos < OH_POS);
        is_seed  = (cur_pos == OH_POS);
        is_b1    = (cur_pos == B1_POS);
        frame_ok = tm_q.ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q.pos  <= LAST_POS;
            tm_q.seen <= 1'b0;
            tm_q.ok   <= 1'b0;
        end else begin
            tm_q <= tm_d;
        end
    end
endmodule

// File: rtl/bip8dsc_keygen.sv
module bip8dsc_keygen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_oh,
    input  logic       is_seed,
    output logic [7:0] key,
    output logic       key_en
);
    import bip8dsc_pkg::*;

    logic [6:0] lfsr_d, lfsr_q;
    ks_step_t   step;

    always_comb begin
        step   = ks_step8(is_seed ? 7'h7F : lfsr_q);
        lfsr_d = is_oh ? lfsr_q : step.nxt;
        key    = step.key;
        key_en = !is_oh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= 7'h7F;
        else        lfsr_q <= lfsr_d;
    end
endmodule

// File: rtl/bip8dsc_bip.sv
module bip8dsc_bip #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       raw,
    input  logic [7:0]       descr,
    input  logic             is_start,
    input  logic             is_b1,
    input  logic             frame_ok,
    output logic [CNT_W-1:0] err_cnt
);
    import bip8dsc_pkg::*;

    typedef struct packed {
        logic [7:0]       acc;
        logic [7:0]       ref_bip;
        logic [CNT_W-1:0] cnt;
    } bip_t;

    bip_t b_d, b_q;
    logic [7:0] ref_now;

    always_comb begin
        b_d = b_q;
        ref_now = b_q.ref_bip;
        if (is_start) begin
            b_d.ref_bip = b_q.acc;
            b_d.acc     = raw;
        end else begin
            b_d.acc = b_q.acc ^ raw;
        end
        if (is_b1 && frame_ok)
            b_d.cnt = b_q.cnt + CNT_W'(pop8(descr ^ ref_now));
        err_cnt = b_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end
endmodule

// File: rtl/bip8dsc_top.sv
module bip8dsc_top #(
    parameter int ROW_BYTES = 1080,
    parameter int ROWS      = 9,
    parameter int A1_CNT    = 12,
    parameter int A2_CNT    = 12,
    parameter int Z0_CNT    = 11,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_fsync,
    input  logic             in_oof,
    input  logic             cfg_descr_off,
    input  logic             cfg_ais_force,
    input  logic             cfg_ais_on_oof,
    output logic [7:0]       out_data,
    output logic             out_par,
    output logic             out_fsync,
    output logic [CNT_W-1:0] b1_err_cnt
);
    typedef struct packed {
        logic [7:0] data;
        logic       par;
        logic       fsync;
    } out_t;

    logic       is_start, is_oh, is_seed, is_b1, frame_ok;
    logic [7:0] key, descr;
    logic       key_en, ais;
    out_t       o_d, o_q;

    bip8dsc_timing #(
        .ROW_BYTES(ROW_BYTES), .ROWS(ROWS),
        .A1_CNT(A1_CNT), .A2_CNT(A2_CNT), .Z0_CNT(Z0_CNT)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .fsync(in_fsync),
        .is_start(is_start), .is_oh(is_oh), .is_seed(is_seed),
        .is_b1(is_b1), .frame_ok(frame_ok)
    );

    bip8dsc_keygen u_keygen (
        .clk(clk), .rst_n(rst_n), .is_oh(is_oh), .is_seed(is_seed),
        .key(key), .key_en(key_en)
    );

    bip8dsc_bip #(.CNT_W(CNT_W)) u_bip (
        .clk(clk), .rst_n(rst_n), .raw(in_data), .descr(descr),
        .is_start(is_start), .is_b1(is_b1), .frame_ok(frame_ok),
        .err_cnt(b1_err_cnt)
    );

    always_comb begin
        descr = (key_en && !cfg_descr_off) ? (in_data ^ key) : in_data;
        ais   = cfg_ais_force | (cfg_ais_on_oof & in_oof);
        o_d.data  = ais ? 8'hFF : descr;
        o_d.par   = ^o_d.data;
        o_d.fsync = in_fsync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_data  = o_q.data;
    assign out_par   = o_q.par;
    assign out_fsync = o_q.fsync;
endmodule

// File: rtl/bip8dsc_chk.sv
module bip8dsc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       in_data,
    input logic             in_fsync,
    input logic             in_oof,
    input logic             cfg_descr_off,
    input logic             cfg_ais_force,
    input logic             cfg_ais_on_oof,
    input logic [7:0]       out_data,
    input logic             out_par,
    input logic             out_fsync,
    input logic [CNT_W-1:0] b1_err_cnt
);
    assert_even_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (^{out_data, out_par}) == 1'b0);

    assert_fsync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_fsync |=> out_fsync);

    assert_ais_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ais_force |=> out_data == 8'hFF);

    assert_ais_oof_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ais_on_oof && in_oof) |=> out_data == 8'hFF);

    assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_descr_off && !cfg_ais_force && !(cfg_ais_on_oof && in_oof))
        |=> out_data == $past(in_data));

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(b1_err_cnt - $past(b1_err_cnt)) <= CNT_W'(8));
endmodule

bind bip8dsc_top bip8dsc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_fsync(in_fsync),
    .in_oof(in_oof), .cfg_descr_off(cfg_descr_off),
    .cfg_ais_force(cfg_ais_force), .cfg_ais_on_oof(cfg_ais_on_oof),
    .out_data(out_data), .out_par(out_par), .out_fsync(out_fsync),
    .b1_err_cnt(b1_err_cnt)
);

// File: tb/bip8dsc_top_test.sv
module bip8dsc_top_test;
    localparam int ROW = 24, NR = 3, A1 = 2, A2 = 2, Z0 = 3, CW = 6;
    localparam int F  = ROW * NR;
    localparam int OH = A1 + A2 + 1 + Z0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic in_fsync = 1'b0, in_oof = 1'b0;
    logic cfg_descr_off = 1'b0, cfg_ais_force = 1'b0, cfg_ais_on_oof = 1'b0;
    logic [7:0] out_data;
    logic out_par, out_fsync;
    logic [CW-1:0] b1_err_cnt;

    int n_chk = 0, n_fail = 0;
    bit oof_rand = 0;
    string scen = "";

    int m_pos = F - 1;
    bit m_seen = 0, m_valid = 0;
    logic [7:0] m_acc = '0, m_ref = '0;
    logic [CW-1:0] m_cnt = '0;

    always #2 clk = ~clk;

    bip8dsc_top #(.ROW_BYTES(ROW), .ROWS(NR), .A1_CNT(A1), .A2_CNT(A2),
                  .Z0_CNT(Z0), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_fsync(in_fsync),
        .in_oof(in_oof), .cfg_descr_off(cfg_descr_off),
        .cfg_ais_force(cfg_ais_force), .cfg_ais_on_oof(cfg_ais_on_oof),
        .out_data(out_data), .out_par(out_par), .out_fsync(out_fsync),
        .b1_err_cnt(b1_err_cnt)
    );

    function automatic logic [7:0] key_at(input int idx);
        logic [6:0] s = 7'h7F;
        logic [7:0] b = '0;
        for (int i = 0; i <= idx; i++)
            for (int j = 7; j >= 0; j--) begin
                b[j] = s[6];
                s = {s[5:0], s[6] ^ s[5]};
            end
        return b;
    endfunction

    function automatic int ones8(input logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += v[i];
        return c;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input bit fs, input bit inj, input logic [7:0] mask);
        int cur;
        logic [7:0] raw, key, descr, expd;
        bit ais, keyon;
        string tag;
        cur = (fs || m_pos == F - 1) ? 0 : m_pos + 1;
        if (cur == 0) begin
            m_valid = m_seen && (m_pos == F - 1);
            m_ref = m_acc;
            m_acc = '0;
        end
        m_seen = m_seen | fs;
        keyon = (cur >= OH) && !cfg_descr_off;
        key = (cur >= OH) ? key_at(cur - OH) : 8'h00;
        raw = 8'($urandom);
        if (inj && cur == ROW) raw = m_ref ^ mask ^ (keyon ? key : 8'h00);
        m_acc ^= raw;
        descr = keyon ? raw ^ key : raw;
        in_oof = oof_rand ? 1'($urandom) : in_oof;
        ais = cfg_ais_force || (cfg_ais_on_oof && in_oof);
        expd = ais ? 8'hFF : descr;
        if (cur == ROW && m_valid) m_cnt = m_cnt + CW'(ones8(descr ^ m_ref));
        m_pos = cur;
        in_data = raw;
        in_fsync = fs;
        @(posedge clk);
        #1;
        if (scen != "") tag = scen;
        else if (cfg_ais_force) tag = "R7";
        else if (ais) tag = "R8";
        else if (cfg_descr_off) tag = "R4";
        else if (cur < OH) tag = "R2";
        else tag = "R3";
        check(tag, out_data, expd);
        check("R9", out_par, ^expd);
        check("R10", out_fsync, fs);
        if (cur == ROW) check(m_valid ? "R5" : "R6", b1_err_cnt, m_cnt);
    endtask

    task automatic frame(input bit fs, input logic [7:0] mask, input int len);
        for (int i = 0; i < len; i++) send(fs && i == 0, 1'b1, mask);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R11", out_data, 0);
        check("R11", out_par, 0);
        check("R11", out_fsync, 0);
        check("R11", b1_err_cnt, 0);
        rst_n = 1'b1;
        // before any sync: position runs from reset (R1), no comparison (R6)
        scen = "R1";
        frame(1'b0, 8'h00, F);
        scen = "";
        frame(1'b1, 8'h55, F);       // first framed: no compare (R6)
        frame(1'b1, 8'h00, F);       // R5 clean
        frame(1'b1, 8'h01, F);       // R5 +1
        frame(1'b1, 8'hFF, F);       // R5 +8
        scen = "R1";
        frame(1'b0, 8'h3C, F);       // free-running wrap
        scen = "";
        frame(1'b1, 8'h0F, 30);      // cut short by the next sync
        frame(1'b1, 8'hFF, F);       // R6 no compare
        frame(1'b1, 8'h0F, F);       // R5 +4
        cfg_descr_off = 1'b1;
        frame(1'b1, 8'h81, F);
        frame(1'b1, 8'h00, F);
        cfg_descr_off = 1'b0;
        cfg_ais_force = 1'b1;        // R7, comparison still counts
        frame(1'b1, 8'h03, F);
        frame(1'b1, 8'h07, F);
        cfg_ais_force = 1'b0;
        cfg_ais_on_oof = 1'b1;
        oof_rand = 1;                // R8 both gated
        frame(1'b1, 8'h10, F);
        cfg_ais_on_oof = 1'b0;       // R8 oof alone has no effect
        frame(1'b1, 8'h00, F);
        oof_rand = 0;
        in_oof = 1'b0;
        cfg_ais_on_oof = 1'b1;       // enable alone has no effect
        frame(1'b1, 8'h00, F);
        cfg_ais_on_oof = 1'b0;
        for (int k = 0; k < 9; k++) frame(1'b1, 8'hFF, F);   // R5 wrap
        for (int k = 0; k < 24; k++) begin
            cfg_descr_off  = ($urandom % 4) == 0;
            cfg_ais_force  = ($urandom % 5) == 0;
            cfg_ais_on_oof = 1'($urandom);
            oof_rand       = 1'($urandom);
            frame(($urandom % 6) != 0, 8'($urandom), F);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule